// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a start column and a burst setting into the column sequence of one memory read or write burst, one column per clock. A start strobe captures the start column and the burst setting. From the next cycle on the block presents one column per cycle with a valid flag. A done flag marks the final column. The column order is either a plain count that wraps inside an aligned block, or an XOR pattern. A full-page setting, allowed only with the plain count, walks the whole column space until it is stopped.

A stop strobe ends a running burst with no further columns. A new start accepted on any cycle replaces the running burst and begins a fresh sequence, so bursts can follow each other with no idle cycle. Bank and row handling, commands and data are out of scope.

The burst setting `mode_i` uses two fields. Bits [2:0] give the length code: 0, 1, 2 and 3 select 1, 2, 4 and 8 columns, and 7 selects full page. Bit [3] selects the order: 0 is sequential and 1 is interleaved.

Top module: `bcol_gen`

## Requirements
- R1: After reset, `col_vld_o`, `done_o` and `mode_err_o` are low and stay low until a start is accepted.
- R2: A start sampled on a rising edge makes `col_vld_o` high in the next cycle with `col_o` equal to the captured start column. With sequential order (mode_i[3]=0) and length codes 0 to 3 (1, 2, 4, 8 columns), each later cycle adds one to the low log2(length) bits of the previous column, wrapping inside that aligned block. The upper bits stay fixed.
- R3: With interleaved order (mode_i[3]=1) and length codes 0 to 3, the k-th column (k from 0) has its low log2(length) bits equal to the start column's low bits XOR k. The upper bits stay fixed.
- R4: Length code 7 with sequential order is full page. The k-th column is (start + k) mod 512, the sequence wraps from 511 to 0, `done_o` never rises, and the burst runs until a stop or a new start.
- R5: Length code 7 with interleaved order is illegal. `mode_err_o` is set and the burst runs as an interleaved burst of 8 columns.
- R6: Length codes 4, 5 and 6 are reserved. `mode_err_o` is set and the burst is one column long.
- R7: `done_o` is high exactly in the cycle that shows the final column of a finite burst. `col_vld_o` is low in the next cycle unless a new start was accepted on that edge.
- R8: A stop sampled with no start ends the burst: `col_vld_o` is low from the next cycle and `done_o` does not rise. A stop while idle has no effect.
- R9: A start sampled while a burst runs, with or without a stop on the same edge, restarts at count 0 from the new start column and the new setting.
- R10: `mode_i` and `start_col_i` are sampled only when a start is accepted. Later changes do not alter the running sequence. `mode_err_o` holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst; captures the start column and the setting |
| stop_i | input | 1 | End the running burst |
| start_col_i | input | 9 | First column of the burst |
| mode_i | input | 4 | [2:0] length code, [3] order (1 = interleaved) |
| col_o | output | 9 | Current column |
| col_vld_o | output | 1 | `col_o` holds a column of the burst |
| done_o | output | 1 | Current column is the final one |
| mode_err_o | output | 1 | Captured setting was illegal or reserved |

## Verification
The bench builds the block with its defaults: a 9-bit column and interleaved ordering enabled. With 512 columns, a full-page burst started near the top of the space crosses the 511-to-0 wrap after a few cycles and can then run once around the whole page. That run also shows that no done pulse appears. Every length code, both orders, illegal and reserved settings, restarts, stops and back-to-back bursts are reachable within a few hundred cycles each.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

   typedef enum logic [2:0] {
      LEN_1    = 3'd0,
      LEN_2    = 3'd1,
      LEN_4    = 3'd2,
      LEN_8    = 3'd3,
      LEN_RSV4 = 3'd4,
      LEN_RSV5 = 3'd5,
      LEN_RSV6 = 3'd6,
      LEN_PAGE = 3'd7
   } len_code_e;

   localparam int unsigned MODE_W    = 4;
   localparam int unsigned ORDER_BIT = 3;
   localparam int unsigned MAX_LOG   = 3;

endpackage

// File: rtl/bcg_mode_dec.sv
module bcg_mode_dec
   import bcg_pkg::*;
#(
   parameter int unsigned COL_W  = 9,
   parameter bit          ILV_EN = 1'b1
) (
   input  logic [MODE_W-1:0] mode_i,
   output logic [COL_W-1:0]  mask_o,
   output logic              ilv_o,
   output logic              page_o,
   output logic              bad_o
);

   localparam logic [COL_W-1:0] ONE  = COL_W'(1);
   localparam logic [COL_W-1:0] ALL  = '1;
   localparam logic [COL_W-1:0] OCT  = (ONE << MAX_LOG) - ONE;

   len_code_e code;
   logic      want_ilv;

   assign code     = len_code_e'(mode_i[2:0]);
   assign want_ilv = mode_i[ORDER_BIT];

   generate
      if (ILV_EN) begin : g_ilv
         assign ilv_o = want_ilv;
      end else begin : g_seq_only
         assign ilv_o = 1'b0;
      end
   endgenerate

   always_comb begin
      mask_o = '0;
      page_o = 1'b0;
      bad_o  = 1'b0;
      unique case (code)
         LEN_1, LEN_2, LEN_4, LEN_8: mask_o = (ONE << mode_i[1:0]) - ONE;
         LEN_PAGE: begin
            if (want_ilv) begin
               mask_o = OCT;
               bad_o  = 1'b1;
            end else begin
               mask_o = ALL;
               page_o = 1'b1;
            end
         end
         default: bad_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/bcg_step_ctr.sv
module bcg_step_ctr #(
   parameter int unsigned COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   input  logic             page_i,
   input  logic             bad_i,
   output logic             act_o,
   output logic [COL_W-1:0] cnt_o,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] mask_o,
   output logic             ilv_o,
   output logic             bad_o,
   output logic             last_o
);

   localparam logic [COL_W-1:0] ONE = COL_W'(1);

   logic page_q;

   assign last_o = act_o && !page_q && (cnt_o == mask_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_o  <= 1'b0;
         cnt_o  <= '0;
         base_o <= '0;
         mask_o <= '0;
         ilv_o  <= 1'b0;
         page_q <= 1'b0;
         bad_o  <= 1'b0;
      end else if (load_i) begin
         act_o  <= 1'b1;
         cnt_o  <= '0;
         base_o <= base_i;
         mask_o <= mask_i;
         ilv_o  <= ilv_i;
         page_q <= page_i;
         bad_o  <= bad_i;
      end else if (stop_i || last_o) begin
         act_o  <= 1'b0;
      end else if (act_o) begin
         cnt_o  <= cnt_o + ONE;
      end
   end

endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map #(
   parameter int unsigned COL_W  = 9,
   parameter bit          ILV_EN = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] cnt_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] sum;

   assign sum = base_i + cnt_i;

   generate
      for (genvar b = 0; b < COL_W; b++) begin : g_bit
         if (ILV_EN) begin : g_both
            assign col_o[b] = !mask_i[b] ? base_i[b]
                            : (ilv_i ? (base_i[b] ^ cnt_i[b]) : sum[b]);
         end else begin : g_plain
            logic unused_ilv;
            assign unused_ilv = ilv_i;
            assign col_o[b]   = mask_i[b] ? sum[b] : base_i[b];
         end
      end
   endgenerate

endmodule

// File: rtl/bcol_gen.sv
module bcol_gen
   import bcg_pkg::*;
#(
   parameter int unsigned COL_W  = 9,
   parameter bit          ILV_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [COL_W-1:0]  start_col_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [COL_W-1:0]  col_o,
   output logic              col_vld_o,
   output logic              done_o,
   output logic              mode_err_o
);

   generate
      if (COL_W < MAX_LOG + 1) begin : g_bad_width
         $error("bcol_gen: COL_W must cover a burst of eight plus one page bit");
      end
   endgenerate

   logic [COL_W-1:0] dec_mask, q_mask, q_cnt, q_base;
   logic             dec_ilv, dec_page, dec_bad, q_ilv;

   bcg_mode_dec #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_dec (
      .mode_i (mode_i),
      .mask_o (dec_mask),
      .ilv_o  (dec_ilv),
      .page_o (dec_page),
      .bad_o  (dec_bad)
   );

   bcg_step_ctr #(.COL_W(COL_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start_i),
      .stop_i (stop_i),
      .base_i (start_col_i),
      .mask_i (dec_mask),
      .ilv_i  (dec_ilv),
      .page_i (dec_page),
      .bad_i  (dec_bad),
      .act_o  (col_vld_o),
      .cnt_o  (q_cnt),
      .base_o (q_base),
      .mask_o (q_mask),
      .ilv_o  (q_ilv),
      .bad_o  (mode_err_o),
      .last_o (done_o)
   );

   bcg_col_map #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_map (
      .base_i (q_base),
      .cnt_i  (q_cnt),
      .mask_i (q_mask),
      .ilv_i  (q_ilv),
      .col_o  (col_o)
   );

endmodule

// File: rtl/bcol_gen_chk.sv
module bcol_gen_chk #(
   parameter int unsigned COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             stop_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [COL_W-1:0] col_o,
   input logic             col_vld_o,
   input logic             done_o,
   input logic             mode_err_o
);

   // R1: with no start, an idle block stays idle
   a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!col_vld_o && !start_i) |=> !col_vld_o);

   // R2 / R9: an accepted start shows its column in the next cycle
   a_r2_first_col: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (col_vld_o && col_o == $past(start_col_i)));

   // R2: an unfinished burst keeps issuing columns
   a_r2_keeps_going: assert property (@(posedge clk) disable iff (!rst_n)
      (col_vld_o && !done_o && !start_i && !stop_i) |=> col_vld_o);

   // R7: the final-column flag only with a valid column
   a_r7_done_valid: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> col_vld_o);

   // R7: the burst ends after its final column
   a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !col_vld_o);

   // R8: a stop ends the burst
   a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> !col_vld_o);

   // R10: the error flag changes only on a start
   a_r10_err_held: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(mode_err_o));

endmodule

bind bcol_gen bcol_gen_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .stop_i      (stop_i),
   .start_col_i (start_col_i),
   .col_o       (col_o),
   .col_vld_o   (col_vld_o),
   .done_o      (done_o),
   .mode_err_o  (mode_err_o)
);

// File: tb/bcol_gen_test.sv
module bcol_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [8:0] start_col_i = '0;
   logic [3:0] mode_i = '0;
   logic [8:0] col_o;
   logic       col_vld_o, done_o, mode_err_o;

   int vectors = 0;
   int fails   = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   bcol_gen uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .start_col_i(start_col_i), .mode_i(mode_i), .col_o(col_o),
      .col_vld_o(col_vld_o), .done_o(done_o), .mode_err_o(mode_err_o)
   );

   // behavioural reference state
   bit m_act = 0, m_ilv = 0, m_page = 0, m_bad = 0;
   int m_base = 0, m_len = 1, m_k = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_act = 0; m_bad = 0; m_k = 0;
      end else if (start_i) begin
         int code;
         code   = int'(mode_i[2:0]);
         m_ilv  = mode_i[3];
         m_page = 0;
         m_bad  = 0;
         if (code <= 3) m_len = 1 << code;
         else if (code == 7) begin
            if (m_ilv) begin m_len = 8; m_bad = 1; end
            else begin m_page = 1; m_len = 512; end
         end else begin m_len = 1; m_bad = 1; end
         m_act  = 1;
         m_k    = 0;
         m_base = int'(start_col_i);
      end else if (stop_i) begin
         m_act = 0;
      end else if (m_act) begin
         if (!m_page && m_k == m_len - 1) m_act = 0;
         else m_k = m_k + 1;
      end
   end

   function automatic int exp_col();
      int lo, blk;
      if (m_page) return (m_base + m_k) % 512;
      lo  = m_base % m_len;
      blk = m_base - lo;
      if (m_ilv) return blk + (lo ^ m_k);
      return blk + ((lo + m_k) % m_len);
   endfunction

   task automatic compare();
      bit e_done;
      e_done = m_act && !m_page && (m_k == m_len - 1);
      vectors++;
      if (col_vld_o !== m_act) begin
         fails++;
         $display("FAIL %s col_vld actual=%0b expected=%0b", cur_req, col_vld_o, m_act);
      end
      if (done_o !== e_done) begin
         fails++;
         $display("FAIL %s done actual=%0b expected=%0b", cur_req, done_o, e_done);
      end
      if (mode_err_o !== m_bad) begin
         fails++;
         $display("FAIL %s mode_err actual=%0b expected=%0b", cur_req, mode_err_o, m_bad);
      end
      if (m_act && int'(col_o) != exp_col()) begin
         fails++;
         $display("FAIL %s col actual=%0d expected=%0d", cur_req, col_o, exp_col());
      end
   endtask

   task automatic cyc(input bit st, input bit sp, input int c, input int md);
      @(negedge clk);
      compare();
      start_i     = st;
      stop_i      = sp;
      start_col_i = 9'(c);
      mode_i      = 4'(md);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      idle(2);
      rst_n = 1'b1;
      idle(3);

      // R2: sequential lengths 1..8
      cur_req = "R2";
      for (int code = 0; code < 4; code++) begin
         cyc(1, 0, 9'h0A6, code); idle(9);
         cyc(1, 0, 9'h1FB, code); idle(9);
      end

      // R3: interleaved lengths 1..8
      cur_req = "R3";
      for (int code = 0; code < 4; code++) begin
         cyc(1, 0, 9'h0B5, 8 + code); idle(9);
         cyc(1, 0, 9'h16E, 8 + code); idle(9);
      end

      // R4: full page across the wrap and once around
      cur_req = "R4";
      cyc(1, 0, 9'h1FC, 7); idle(520);
      cyc(0, 1, 0, 0); idle(3);

      // R5: interleave with full page is illegal, runs as 8
      cur_req = "R5";
      cyc(1, 0, 9'h133, 15); idle(10);

      // R6: reserved length codes
      cur_req = "R6";
      for (int code = 4; code < 7; code++) begin
         cyc(1, 0, 9'h055, code); idle(3);
         cyc(1, 0, 9'h0AA, 8 + code); idle(3);
      end
      cyc(1, 0, 9'h010, 2); idle(6);

      // R7: back-to-back, start on the done cycle
      cur_req = "R7";
      cyc(1, 0, 9'h021, 2); idle(3);
      cyc(1, 0, 9'h0E7, 11); idle(9);

      // R8: stop mid-burst and stop while idle
      cur_req = "R8";
      cyc(1, 0, 9'h044, 3); idle(3);
      cyc(0, 1, 0, 0); idle(2);
      cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); idle(2);

      // R9: restart mid-burst, restart together with stop
      cur_req = "R9";
      cyc(1, 0, 9'h0C8, 3); idle(2);
      cyc(1, 0, 9'h1E3, 10); idle(1);
      cyc(1, 1, 9'h07D, 1); idle(5);

      // R10: inputs changing during a burst are ignored
      cur_req = "R10";
      cyc(1, 0, 9'h0F9, 15);
      for (int i = 0; i < 4; i++) cyc(0, 0, 9'h1FF - i, i);
      idle(8);
      cyc(1, 0, 9'h19A, 3);
      for (int i = 0; i < 9; i++) cyc(0, 0, 9'h003 + i, 7 + i);
      idle(2);

      @(negedge clk);
      compare();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule